// File: doc/BRIEF.md
# Self-ID Sequence Parser

This block sits behind the physical layer of a serial bus. It takes the self-identification quadlets that the physical layer collects after a bus reset. Quadlets arrive one per accepted transfer on a valid/ready stream, with a flag that marks the final quadlet of the receive buffer. Each node describes itself in one to four consecutive quadlets. Bit 0 of a quadlet, the continuation bit, says that another quadlet of the same node follows. The parser groups quadlets into sequences and checks that each follow-on quadlet is numbered in order. For every well-formed sequence it produces one record on a second valid/ready stream: the node identifier, the attributes carried in the first quadlet, the number of quadlets, and the state of every port as a packed array of 2-bit codes.

A malformed sequence produces no record. Instead, a one-cycle error pulse carries the node identifier of the offending quadlet. The parser then drops input up to and including the next quadlet whose continuation bit is clear. If the error fell on a quadlet with the continuation bit clear, or on the last quadlet of the buffer, nothing is dropped. Back-pressure works as follows. A record stays on the output until it is taken. While a record is waiting and `out_ready` is low, `in_ready` is low, so no quadlet is lost or overwritten. Port 0 of `out_ports` sits at bits 1:0, port p at bits 2p+1:2p.

Top module: `selfid_seq_parser`

## Requirements
- R1: The first quadlet of a sequence is decoded as follows: node identifier at bits 29:24, link active at bit 22, gap count at bits 21:16, speed code at bits 15:14, contender at bit 11, power class at bits 10:8, initiated reset at bit 1. The record reports these values.
- R2: Quadlets are grouped while bit 0 is set. A sequence closes on the first quadlet with bit 0 clear, and `out_qcount` reports its length, from 1 to 4. A closing quadlet flagged as last of buffer is not an error.
- R3: A follow-on quadlet must have bit 23 set and carry in bits 22:20 a number that starts at 0 for the first follow-on and rises by one per quadlet. Otherwise the sequence is in error.
- R4: A fourth quadlet with bit 0 still set is an error.
- R5: A quadlet with bit 0 set that is flagged as last of buffer is an error.
- R6: Port p is read from quadlet (p+5)/8 at bit offset 16−2·((p+5) mod 8). Ports 0, 1 and 2 come from bits 7:6, 5:4 and 3:2 of the first quadlet. Follow-on quadlet i holds ports 8i−5 to 8i+2 at bits 17:16 down to 3:2. The codes are 0 absent, 1 not connected, 2 parent, 3 child.
- R7: Ports with index n·8−5 or above, for a sequence of n quadlets, read as code 0.
- R8: `out_valid` rises on the clock edge that accepts the closing quadlet. The record stays stable until a cycle with `out_ready` high.
- R9: `in_ready` is low exactly while `out_valid` is high and `out_ready` is low.
- R10: An error produces no record and a one-cycle `err_pulse` with `err_node` set to bits 29:24 of the quadlet that failed. When that quadlet has bit 0 set and is not last of buffer, input is dropped through the next quadlet with bit 0 clear (or flagged last). Parsing then restarts with a new first quadlet.
- R11: A low `rst_n` at a clock edge clears the quadlet count, the expected sequence number, the drop state, `out_valid` and `err_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Quadlet offered |
| in_ready | output | 1 | Quadlet can be accepted |
| in_data | input | 32 | Self-identification quadlet |
| in_last | input | 1 | Quadlet is the last of the buffer |
| out_valid | output | 1 | Record available |
| out_ready | input | 1 | Record taken this cycle |
| out_node | output | 6 | Node identifier |
| out_link_active | output | 1 | Link layer active |
| out_gap | output | 6 | Gap count |
| out_speed | output | 2 | Speed code |
| out_contender | output | 1 | Contender flag |
| out_power | output | 3 | Power class |
| out_init_reset | output | 1 | Node initiated the reset |
| out_qcount | output | 3 | Quadlets in the sequence |
| out_ports | output | 54 | 27 packed 2-bit port states |
| err_pulse | output | 1 | Protocol error, one cycle |
| err_node | output | 6 | Node identifier of the failing quadlet |

## Verification
Properties check on every cycle that `in_ready` falls while a record waits unclaimed, that a waiting record holds steady, and that the reported length stays between one and four. They also check that a one-quadlet record has all ports above 2 at zero, and that an error never coincides with a new record. The bench's scenarios show the rest. A sweep over every sequence length with varied attributes proves the bit positions of each field and the offset-by-five port mapping. Injected faults show that the wrong numbering, the missing extended flag, the over-long chain and the truncated buffer each raise an error with the right node. Those scenarios also show that the dropped quadlets produce no record and that parsing resumes cleanly afterwards.

// File: rtl/selfid_pkg.sv
package selfid_pkg;
  localparam int QUAD_W = 32;
  localparam int NODE_W = 6;
  localparam int SEQN_W = 3;

  typedef struct packed {
    logic [NODE_W-1:0] node;
    logic              link;
    logic [5:0]        gap;
    logic [1:0]        speed;
    logic              contender;
    logic [2:0]        power;
    logic              init_reset;
  } node_attr_t;

  typedef enum logic [1:0] {
    PST_ABSENT = 2'd0,
    PST_OPEN   = 2'd1,
    PST_PARENT = 2'd2,
    PST_CHILD  = 2'd3
  } port_state_e;
endpackage

// File: rtl/selfid_attr_unpack.sv
module selfid_attr_unpack
  import selfid_pkg::*;
(
  input  logic [QUAD_W-1:0] quad,
  output node_attr_t        attr
);
  assign attr.node       = quad[29:24];
  assign attr.link       = quad[22];
  assign attr.gap        = quad[21:16];
  assign attr.speed      = quad[15:14];
  assign attr.contender  = quad[11];
  assign attr.power      = quad[10:8];
  assign attr.init_reset = quad[1];
endmodule

// File: rtl/selfid_port_map.sv
module selfid_port_map
  import selfid_pkg::*;
#(
  parameter int MAX_QUADS = 4,
  parameter int PORTS     = MAX_QUADS * 8 - 5,
  parameter int IDX_W     = $clog2(MAX_QUADS)
) (
  input  logic [QUAD_W-1:0]  quad,
  input  logic [IDX_W-1:0]   qidx,
  input  logic               restart,
  input  logic [2*PORTS-1:0] cur,
  output logic [2*PORTS-1:0] nxt
);
  for (genvar p = 0; p < PORTS; p++) begin : g_port
    localparam int QI  = (p + 5) / 8;
    localparam int OFF = 16 - 2 * ((p + 5) % 8);
    always_comb begin
      if (int'(qidx) == QI)
        nxt[2*p +: 2] = quad[OFF +: 2];
      else if (restart)
        nxt[2*p +: 2] = PST_ABSENT;
      else
        nxt[2*p +: 2] = cur[2*p +: 2];
    end
  end
endmodule

// File: rtl/selfid_chain_check.sv
module selfid_chain_check
  import selfid_pkg::*;
#(
  parameter int MAX_QUADS = 4,
  parameter int CNT_W     = $clog2(MAX_QUADS + 1)
) (
  input  logic [QUAD_W-1:0] quad,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [SEQN_W-1:0] exp_seq,
  input  logic              last,
  output logic              is_first,
  output logic              cont,
  output logic              err,
  output logic              close
);
  logic bad_link, too_long, trunc;

  always_comb begin
    is_first = (cnt == '0);
    cont     = quad[0];
    bad_link = !is_first && (!quad[23] || (quad[22:20] != exp_seq));
    too_long = cont && (int'(cnt) == MAX_QUADS - 1);
    trunc    = cont && last;
    err      = bad_link || too_long || trunc;
    close    = !cont && !bad_link;
  end
endmodule

// File: rtl/selfid_seq_parser.sv
module selfid_seq_parser
  import selfid_pkg::*;
#(
  parameter int MAX_QUADS = 4,
  parameter int PORTS     = MAX_QUADS * 8 - 5,
  parameter int CNT_W     = $clog2(MAX_QUADS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [31:0]        in_data,
  input  logic               in_last,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [5:0]         out_node,
  output logic               out_link_active,
  output logic [5:0]         out_gap,
  output logic [1:0]         out_speed,
  output logic               out_contender,
  output logic [2:0]         out_power,
  output logic               out_init_reset,
  output logic [CNT_W-1:0]   out_qcount,
  output logic [2*PORTS-1:0] out_ports,
  output logic               err_pulse,
  output logic [5:0]         err_node
);
  localparam int IDX_W = $clog2(MAX_QUADS);

  logic [CNT_W-1:0]   cnt_q;
  logic [SEQN_W-1:0]  seq_q;
  logic               skip_q;
  node_attr_t         attr_q, attr_dec, attr_now, out_attr_q;
  logic [2*PORTS-1:0] ports_q, ports_nxt;
  logic               take, is_first, cont, err, close;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  selfid_attr_unpack u_attr (.quad(in_data), .attr(attr_dec));

  selfid_chain_check #(.MAX_QUADS(MAX_QUADS), .CNT_W(CNT_W)) u_chain (
    .quad(in_data), .cnt(cnt_q), .exp_seq(seq_q), .last(in_last),
    .is_first(is_first), .cont(cont), .err(err), .close(close)
  );

  selfid_port_map #(.MAX_QUADS(MAX_QUADS), .PORTS(PORTS), .IDX_W(IDX_W)) u_ports (
    .quad(in_data), .qidx(cnt_q[IDX_W-1:0]), .restart(is_first),
    .cur(ports_q), .nxt(ports_nxt)
  );

  assign attr_now = is_first ? attr_dec : attr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      seq_q      <= '0;
      skip_q     <= 1'b0;
      attr_q     <= '0;
      ports_q    <= '0;
      out_valid  <= 1'b0;
      out_attr_q <= '0;
      out_qcount <= '0;
      out_ports  <= '0;
      err_pulse  <= 1'b0;
      err_node   <= '0;
    end else begin
      err_pulse <= 1'b0;
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (take) begin
        if (skip_q) begin
          if (!cont || in_last) skip_q <= 1'b0;
        end else begin
          attr_q  <= attr_now;
          ports_q <= ports_nxt;
          if (err) begin
            err_pulse <= 1'b1;
            err_node  <= in_data[29:24];
            cnt_q     <= '0;
            seq_q     <= '0;
            skip_q    <= cont && !in_last;
          end else if (close) begin
            out_valid  <= 1'b1;
            out_attr_q <= attr_now;
            out_ports  <= ports_nxt;
            out_qcount <= cnt_q + 1'b1;
            cnt_q      <= '0;
            seq_q      <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
            seq_q <= is_first ? '0 : seq_q + 1'b1;
          end
        end
      end
    end
  end

  assign out_node        = out_attr_q.node;
  assign out_link_active = out_attr_q.link;
  assign out_gap         = out_attr_q.gap;
  assign out_speed       = out_attr_q.speed;
  assign out_contender   = out_attr_q.contender;
  assign out_power       = out_attr_q.power;
  assign out_init_reset  = out_attr_q.init_reset;
endmodule

// File: rtl/selfid_seq_parser_chk.sv
module selfid_seq_parser_chk #(
  parameter int MAX_QUADS = 4,
  parameter int PORTS     = MAX_QUADS * 8 - 5,
  parameter int CNT_W     = $clog2(MAX_QUADS + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic               out_valid,
  input logic               out_ready,
  input logic [CNT_W-1:0]   out_qcount,
  input logic [2*PORTS-1:0] out_ports,
  input logic               err_pulse
);
  // R9
  stall_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R8
  hold_record_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_ports) && $stable(out_qcount)));

  // R2
  qcount_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_qcount >= 1 && int'(out_qcount) <= MAX_QUADS));

  // R7
  absent_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_qcount == 1) |-> ((out_ports >> 6) == '0));

  // R10
  err_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> !$rose(out_valid));

  // R10
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> $past(in_valid && in_ready));

  // R11
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && !err_pulse));
endmodule

bind selfid_seq_parser selfid_seq_parser_chk #(.MAX_QUADS(MAX_QUADS), .PORTS(PORTS), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/selfid_seq_parser_test.sv
`timescale 1ns/1ps
module selfid_seq_parser_test;
  localparam int MQ = 4;
  localparam int NP = MQ * 8 - 5;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_last = 0, out_ready = 1;
  logic [31:0] in_data = '0;
  logic in_ready, out_valid, out_link_active, out_contender, out_init_reset, err_pulse;
  logic [5:0] out_node, out_gap, err_node;
  logic [1:0] out_speed;
  logic [2:0] out_power, out_qcount;
  logic [2*NP-1:0] out_ports;

  int checks = 0, errors = 0;

  typedef struct packed {
    logic [5:0] node; logic link; logic [5:0] gap; logic [1:0] speed;
    logic cont; logic [2:0] power; logic ir; logic [2:0] qc; logic [2*NP-1:0] ports;
  } exp_t;
  exp_t exq[$];
  logic [5:0] eerr[$];

  selfid_seq_parser uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .out_valid(out_valid), .out_ready(out_ready),
    .out_node(out_node), .out_link_active(out_link_active), .out_gap(out_gap),
    .out_speed(out_speed), .out_contender(out_contender), .out_power(out_power),
    .out_init_reset(out_init_reset), .out_qcount(out_qcount), .out_ports(out_ports),
    .err_pulse(err_pulse), .err_node(err_node)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] ps(input int seed, input int p);
    return 2'((p * 3 + seed + p / 5) % 4);
  endfunction

  function automatic logic [31:0] mk_first(input logic [5:0] node, input logic link, input logic [5:0] gap,
      input logic [1:0] speed, input logic cont, input logic [2:0] pwr, input logic ir,
      input logic [1:0] a, input logic [1:0] b, input logic [1:0] c, input logic more);
    logic [31:0] q = '0;
    q[31:30] = 2'b10; q[29:24] = node; q[22] = link; q[21:16] = gap; q[15:14] = speed;
    q[11] = cont; q[10:8] = pwr; q[7:6] = a; q[5:4] = b; q[3:2] = c; q[1] = ir; q[0] = more;
    return q;
  endfunction

  function automatic logic [31:0] mk_next(input logic [5:0] node, input logic [2:0] seq, input logic ext,
      input logic [15:0] p8, input logic more);
    logic [31:0] q = '0;
    q[31:30] = 2'b10; q[29:24] = node; q[23] = ext; q[22:20] = seq;
    for (int k = 0; k < 8; k++) q[17-2*k -: 2] = p8[2*k +: 2];
    q[0] = more;
    return q;
  endfunction

  task automatic send(input logic [31:0] q, input logic last);
    @(negedge clk);
    in_valid = 1; in_data = q; in_last = last;
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1;
    in_valid = 0; in_last = 0;
  endtask

  task automatic run_seq(input int n, input int seed, input logic [5:0] node, input logic lastf);
    exp_t e;
    logic [15:0] p8;
    e.node = node; e.link = seed[0]; e.gap = 6'((seed * 5 + node) % 64); e.speed = 2'(seed >> 1);
    e.cont = seed[3]; e.power = 3'((seed + node) % 8); e.ir = seed[2] ^ seed[0]; e.qc = 3'(n);
    e.ports = '0;
    for (int p = 0; p < 8 * n - 5; p++) e.ports[2*p +: 2] = ps(seed, p);
    exq.push_back(e);
    send(mk_first(node, e.link, e.gap, e.speed, e.cont, e.power, e.ir,
                  ps(seed, 0), ps(seed, 1), ps(seed, 2), n > 1), lastf && n == 1);
    for (int i = 1; i < n; i++) begin
      p8 = '0;
      for (int k = 0; k < 8; k++) p8[2*k +: 2] = ps(seed, 8 * i - 5 + k);
      send(mk_next(node, 3'(i - 1), 1'b1, p8, i < n - 1), lastf && i == n - 1);
    end
    chk("R8", "out_valid right after closing quadlet", 64'(out_valid), 64'(1));
  endtask

  // output and error monitor
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (exq.size() == 0) chk("R10", "unexpected record", 64'(1), 64'(0));
      else begin
        exp_t e;
        logic [63:0] m;
        e = exq.pop_front();
        m = (64'(1) << (2 * (8 * int'(e.qc) - 5))) - 1;
        chk("R1", "node", 64'(out_node), 64'(e.node));
        chk("R1", "link", 64'(out_link_active), 64'(e.link));
        chk("R1", "gap", 64'(out_gap), 64'(e.gap));
        chk("R1", "speed", 64'(out_speed), 64'(e.speed));
        chk("R1", "contender", 64'(out_contender), 64'(e.cont));
        chk("R1", "power", 64'(out_power), 64'(e.power));
        chk("R1", "init_reset", 64'(out_init_reset), 64'(e.ir));
        chk("R2", "qcount", 64'(out_qcount), 64'(e.qc));
        chk("R6", "ports in range", 64'(out_ports) & m, 64'(e.ports) & m);
        chk("R7", "ports beyond", 64'(out_ports) & ~m, 64'(0));
      end
    end
    if (rst_n && err_pulse) begin
      if (eerr.size() == 0) chk("R3", "unexpected error", 64'(1), 64'(0));
      else chk("R10", "err_node", 64'(err_node), 64'(eerr.pop_front()));
    end
  end

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog R2: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [15:0] z8;
    z8 = 16'h5555;
    repeat (3) @(negedge clk);
    chk("R11", "out_valid in reset", 64'(out_valid), 64'(0));
    chk("R11", "err_pulse in reset", 64'(err_pulse), 64'(0));
    chk("R9", "in_ready in reset", 64'(in_ready), 64'(1));
    @(posedge clk); #1 rst_n = 1;

    // sweep of lengths and field values
    for (int n = 1; n <= MQ; n++)
      for (int s = 0; s < 16; s++)
        run_seq(n, s + 16 * n, 6'((n * 13 + s * 7) % 63), s[0]);

    // R3 wrong sequence number on first follow-on
    eerr.push_back(6'd11);
    send(mk_first(6'd11, 1, 6'd3, 2'd1, 0, 3'd0, 0, 2'd1, 2'd1, 2'd1, 1), 0);
    send(mk_next(6'd11, 3'd1, 1, z8, 0), 0);
    run_seq(2, 5, 6'd20, 0);

    // R3 R10 missing extended flag, continuation set: drop through next closing quadlet
    eerr.push_back(6'd12);
    send(mk_first(6'd12, 0, 6'd4, 2'd2, 1, 3'd1, 0, 2'd2, 2'd2, 2'd2, 1), 0);
    send(mk_next(6'd12, 3'd0, 0, z8, 1), 0);
    send(mk_next(6'd12, 3'd1, 1, z8, 1), 0);
    send(mk_first(6'd13, 0, 6'd4, 2'd2, 1, 3'd1, 0, 2'd2, 2'd2, 2'd2, 0), 0);
    run_seq(3, 9, 6'd21, 0);

    // R3 repeated sequence number on third quadlet
    eerr.push_back(6'd14);
    send(mk_first(6'd14, 1, 6'd5, 2'd0, 0, 3'd2, 1, 2'd3, 2'd0, 2'd1, 1), 0);
    send(mk_next(6'd14, 3'd0, 1, z8, 1), 0);
    send(mk_next(6'd14, 3'd0, 1, z8, 0), 0);
    run_seq(1, 3, 6'd22, 0);

    // R4 over-long chain, then drop two quadlets
    eerr.push_back(6'd15);
    send(mk_first(6'd15, 1, 6'd6, 2'd3, 1, 3'd3, 0, 2'd1, 2'd2, 2'd3, 1), 0);
    send(mk_next(6'd15, 3'd0, 1, z8, 1), 0);
    send(mk_next(6'd15, 3'd1, 1, z8, 1), 0);
    send(mk_next(6'd15, 3'd2, 1, z8, 1), 0);
    send(mk_first(6'd16, 0, 6'd1, 2'd0, 0, 3'd0, 0, 2'd1, 2'd1, 2'd1, 1), 0);
    send(mk_first(6'd16, 0, 6'd1, 2'd0, 0, 3'd0, 0, 2'd1, 2'd1, 2'd1, 0), 0);
    run_seq(4, 7, 6'd23, 0);

    // R5 truncated buffer: next quadlet starts fresh
    eerr.push_back(6'd17);
    send(mk_first(6'd17, 0, 6'd2, 2'd1, 0, 3'd4, 1, 2'd0, 2'd3, 2'd0, 1), 1);
    run_seq(1, 11, 6'd24, 0);
    eerr.push_back(6'd18);
    send(mk_first(6'd18, 0, 6'd2, 2'd1, 0, 3'd4, 1, 2'd0, 2'd3, 2'd0, 1), 0);
    send(mk_next(6'd18, 3'd0, 1, z8, 1), 1);
    run_seq(2, 12, 6'd25, 1);

    // R9 R8 back-pressure
    repeat (2) @(posedge clk);
    #1 out_ready = 0;
    run_seq(1, 4, 6'd30, 0);
    exq.push_back('{node: 6'd31, link: 1'b1, gap: 6'd9, speed: 2'd2, cont: 1'b1, power: 3'd5, ir: 1'b0,
                    qc: 3'd1, ports: 54'(6'b10_01_11)});
    @(negedge clk);
    in_valid = 1; in_last = 0;
    in_data = mk_first(6'd31, 1, 6'd9, 2'd2, 1, 3'd5, 0, 2'd3, 2'd1, 2'd2, 0);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk("R9", "in_ready low while stalled", 64'(in_ready), 64'(0));
      chk("R8", "record held while stalled", 64'(out_valid), 64'(1));
      chk("R8", "node held while stalled", 64'(out_node), 64'(30));
    end
    @(posedge clk); #1 out_ready = 1;
    @(posedge clk); #1 in_valid = 0;
    repeat (3) @(negedge clk);

    // R11 reset mid-sequence clears the quadlet count
    send(mk_first(6'd40, 0, 6'd0, 2'd0, 0, 3'd0, 0, 2'd0, 2'd0, 2'd0, 1), 0);
    @(posedge clk); #1 rst_n = 0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
    chk("R11", "out_valid after reset", 64'(out_valid), 64'(0));
    run_seq(1, 13, 6'd41, 0);

    repeat (5) @(negedge clk);
    chk("R2", "records all delivered", 64'(exq.size()), 64'(0));
    chk("R10", "errors all reported", 64'(eerr.size()), 64'(0));
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule